// File: doc/BRIEF.md
# Resynchronizable Serial Sample Output Port

This block places decimated receiver samples onto a three-wire synchronous serial output: a bit clock, a one-bit frame marker and a data line. All three come from a single, faster input clock. The bit clock is the input clock divided by an even ratio that software sets. Each sample is sent as a 16-bit or 24-bit frame, most significant bit first. The upstream decimation filter is outside this block; it appears here only as a strobe with a data word.

Several of these ports can run from one shared input clock and be brought into alignment by a common active-low sync line. Sync acts asynchronously. It clears the divide counter, the frame sequencer and the holding stage, and it parks the bit clock high and the frame marker low. Sync is released through a two-stage synchronizer. Because of that, the restart after every sync happens at the same input-clock edge relative to the release. After a sync, a valid flag stays low until enough frames have gone out for filter transients to have cleared.

Top module: `serial_frame_port`

## Requirements
- R1: While `rst_n` is low, `bit_clk` is 1, and `frame_sync`, `ser_data` and `smp_valid` are 0.
- R2: While `sync_n` is low, `bit_clk` is 1 and `frame_sync` and `smp_valid` are 0. This takes effect without waiting for a clock edge.
- R3: A low pulse on `sync_n` is recognized even when it is shorter than half an input clock period and falls between clock edges.
- R4: Count the rising edges of `clk_in` that follow the rising edge of `sync_n`. The first falling edge of `bit_clk` comes on edge number `div_half`+2.
- R5: `bit_clk` is low for `div_half` input clocks and then high for `div_half` input clocks, so its period is 2·`div_half`.
- R6: `ser_data` and `frame_sync` change only when `bit_clk` falls. `frame_sync` is high for exactly one bit period, and that period carries the first (most significant) bit of the frame.
- R7: `frame_long`=1 sends all 24 bits of `smp_data`, starting with bit 23. `frame_long`=0 sends 16 bits, which are `smp_data[23:8]`.
- R8: A strobe that arrives while a frame is shifting is held. Its frame starts right after the last bit of the current frame, so the two frame markers are 24 or 16 bit periods apart.
- R9: After sync is released, `smp_valid` is 0 during frames 1 to 11 and 1 from frame 12 onward.
- R10: If the strobes keep the same timing relative to the release, the delay from sync release to the first frame marker is the same on every sync.
- R11: Strobes that arrive while sync is held are discarded. No frame is sent after release until a new strobe arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Fast input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_n | input | 1 | Asynchronous active-low resynchronization |
| div_half | input | DIV_W | Input clocks per half bit-clock period |
| frame_long | input | 1 | 1 = 24-bit frames, 0 = 16-bit frames |
| smp_stb | input | 1 | One-cycle strobe: a new sample is present |
| smp_data | input | DATA_W | Sample word, left-aligned |
| bit_clk | output | 1 | Serial bit clock |
| frame_sync | output | 1 | One-bit frame marker |
| ser_data | output | 1 | Serial data, changes on the falling edge of bit_clk |
| smp_valid | output | 1 | High once post-sync transients have cleared |

## Verification
A wrong divide count shows up within one bit period as a bit clock with the wrong length or a first falling edge on the wrong input edge. A wrong count in the sequencer appears at the end of the next frame: a word is truncated or shifted, or the second marker of a back-to-back pair arrives early or late. If the post-sync frame counter is off, the valid flag flips one frame early or late around frame 12. If the holding register is not cleared by sync, a frame goes out after release although no strobe was given.

// File: rtl/sfp_pkg.sv
package sfp_pkg;
  typedef struct packed {
    logic fall;
    logic rise;
  } tick_t;
endpackage

// File: rtl/sfp_sync_release.sv
module sfp_sync_release (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_n,
  output logic hold
);
  logic clr_n;
  logic s1_q, s2_q;

  assign clr_n = rst_n & sync_n;

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign hold = ~s2_q;
endmodule

// File: rtl/sfp_clk_div.sv
module sfp_clk_div #(
  parameter int unsigned DIV_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hold,
  input  logic [DIV_W-1:0]   div_half,
  output logic               clk_q,
  output sfp_pkg::tick_t     tick
);
  localparam int unsigned CW = DIV_W + 1;

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             clk_d;
  logic [CW-1:0]    cnt_inc;
  logic             term;

  assign cnt_inc = {1'b0, cnt_q} + CW'(1);
  assign term    = (cnt_inc >= {1'b0, div_half});

  always_comb begin
    cnt_d = cnt_q;
    clk_d = clk_q;
    if (hold) begin
      cnt_d = '0;
      clk_d = 1'b1;
    end else if (term) begin
      cnt_d = '0;
      clk_d = ~clk_q;
    end else begin
      cnt_d = cnt_inc[DIV_W-1:0];
    end
  end

  always_comb begin
    tick.fall = ~hold & term & clk_q;
    tick.rise = ~hold & term & ~clk_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      clk_q <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      clk_q <= clk_d;
    end
  end

  AST_HALF_BOUND: assert property (@(posedge clk) disable iff (!rst_n || hold)
    $stable(div_half) |-> ((cnt_q < div_half) || (cnt_q == '0))); // R5
endmodule

// File: rtl/sfp_frame_seq.sv
module sfp_frame_seq #(
  parameter int unsigned DATA_W   = 24,
  parameter int unsigned SHORT_W  = 16,
  parameter int unsigned SKIP_CNT = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hold,
  input  sfp_pkg::tick_t     tick,
  input  logic               frame_long,
  input  logic               smp_stb,
  input  logic [DATA_W-1:0]  smp_data,
  output logic               fs_q,
  output logic               ser_q,
  output logic               valid_q
);
  localparam int unsigned BCW = $clog2(DATA_W);
  localparam int unsigned VCW = $clog2(SKIP_CNT + 1);

  logic [DATA_W-1:0] sh_q, sh_d;
  logic [DATA_W-1:0] hdat_q, hdat_d;
  logic              hfull_q, hfull_d;
  logic              busy_q, busy_d;
  logic [BCW-1:0]    bcnt_q, bcnt_d;
  logic              fs_d, ser_d;
  logic [VCW-1:0]    vcnt_q, vcnt_d;
  logic [BCW-1:0]    last_idx;
  logic              at_end;

  assign last_idx = frame_long ? BCW'(DATA_W - 1) : BCW'(SHORT_W - 1);
  assign at_end   = ~busy_q | (bcnt_q == last_idx);

  always_comb begin
    sh_d    = sh_q;
    hdat_d  = hdat_q;
    hfull_d = hfull_q;
    busy_d  = busy_q;
    bcnt_d  = bcnt_q;
    fs_d    = fs_q;
    ser_d   = ser_q;
    vcnt_d  = vcnt_q;
    if (hold) begin
      sh_d    = '0;
      hdat_d  = '0;
      hfull_d = 1'b0;
      busy_d  = 1'b0;
      bcnt_d  = '0;
      fs_d    = 1'b0;
      ser_d   = 1'b0;
      vcnt_d  = '0;
    end else begin
      if (smp_stb) begin
        hfull_d = 1'b1;
        hdat_d  = smp_data;
      end
      if (tick.fall) begin
        if (!at_end) begin
          ser_d  = sh_q[DATA_W-1];
          sh_d   = sh_q << 1;
          bcnt_d = bcnt_q + BCW'(1);
          fs_d   = 1'b0;
        end else if (hfull_q) begin
          ser_d  = hdat_q[DATA_W-1];
          sh_d   = hdat_q << 1;
          bcnt_d = '0;
          busy_d = 1'b1;
          fs_d   = 1'b1;
          if (!smp_stb) begin
            hfull_d = 1'b0;
          end
          if (vcnt_q < VCW'(SKIP_CNT)) begin
            vcnt_d = vcnt_q + VCW'(1);
          end
        end else begin
          busy_d = 1'b0;
          fs_d   = 1'b0;
          ser_d  = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      hdat_q  <= '0;
      hfull_q <= 1'b0;
      busy_q  <= 1'b0;
      bcnt_q  <= '0;
      fs_q    <= 1'b0;
      ser_q   <= 1'b0;
      vcnt_q  <= '0;
    end else begin
      sh_q    <= sh_d;
      hdat_q  <= hdat_d;
      hfull_q <= hfull_d;
      busy_q  <= busy_d;
      bcnt_q  <= bcnt_d;
      fs_q    <= fs_d;
      ser_q   <= ser_d;
      vcnt_q  <= vcnt_d;
    end
  end

  assign valid_q = (vcnt_q == VCW'(SKIP_CNT));

  AST_FS_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fs_q) |-> $past(tick.fall)); // R6

  AST_VALID_AFTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(hold) |-> !valid_q); // R9

  AST_LOAD_NEEDS_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(hfull_q)); // R8
endmodule

// File: rtl/serial_frame_port.sv
module serial_frame_port #(
  parameter int unsigned DATA_W   = 24,
  parameter int unsigned SHORT_W  = 16,
  parameter int unsigned DIV_W    = 8,
  parameter int unsigned SKIP_CNT = 12
) (
  input  logic              clk_in,
  input  logic              rst_n,
  input  logic              sync_n,
  input  logic [DIV_W-1:0]  div_half,
  input  logic              frame_long,
  input  logic              smp_stb,
  input  logic [DATA_W-1:0] smp_data,
  output logic              bit_clk,
  output logic              frame_sync,
  output logic              ser_data,
  output logic              smp_valid
);
  logic           hold;
  logic           clk_q;
  sfp_pkg::tick_t tick;
  logic           fs_q, ser_q, valid_q;

  sfp_sync_release u_rel (
    .clk    (clk_in),
    .rst_n  (rst_n),
    .sync_n (sync_n),
    .hold   (hold)
  );

  sfp_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk      (clk_in),
    .rst_n    (rst_n),
    .hold     (hold),
    .div_half (div_half),
    .clk_q    (clk_q),
    .tick     (tick)
  );

  sfp_frame_seq #(.DATA_W(DATA_W), .SHORT_W(SHORT_W), .SKIP_CNT(SKIP_CNT)) u_seq (
    .clk        (clk_in),
    .rst_n      (rst_n),
    .hold       (hold),
    .tick       (tick),
    .frame_long (frame_long),
    .smp_stb    (smp_stb),
    .smp_data   (smp_data),
    .fs_q       (fs_q),
    .ser_q      (ser_q),
    .valid_q    (valid_q)
  );

  assign bit_clk    = clk_q | hold;
  assign frame_sync = fs_q & ~hold;
  assign ser_data   = ser_q & ~hold;
  assign smp_valid  = valid_q & ~hold;

  AST_IDLE_WHILE_SYNC: assert property (@(posedge clk_in) disable iff (!rst_n)
    !sync_n |-> (bit_clk && !frame_sync && !smp_valid)); // R2

  AST_FS_NEEDS_CLK_LOW: assert property (@(posedge clk_in) disable iff (!rst_n)
    $rose(frame_sync) |-> !bit_clk); // R6
endmodule

// File: tb/serial_frame_port_bench.sv
module serial_frame_port_bench;
  localparam int CLK_P = 10;

  logic        clk_in = 1'b0;
  logic        rst_n;
  logic        sync_n;
  logic [7:0]  div_half;
  logic        frame_long;
  logic        smp_stb;
  logic [23:0] smp_data;
  logic        bit_clk, frame_sync, ser_data, smp_valid;

  int vectors = 0;
  int errors  = 0;

  serial_frame_port u_serial_frame_port (
    .clk_in(clk_in), .rst_n(rst_n), .sync_n(sync_n), .div_half(div_half),
    .frame_long(frame_long), .smp_stb(smp_stb), .smp_data(smp_data),
    .bit_clk(bit_clk), .frame_sync(frame_sync), .ser_data(ser_data),
    .smp_valid(smp_valid)
  );

  always #(CLK_P/2) clk_in = ~clk_in;

  // receiver model: samples on rising bit_clk, observed at falling clk_in
  int          cyc = 0;
  logic        bc_prev = 1'b1;
  logic        fs_prev = 1'b0;
  int          rise_cnt = 0;
  int          fs_cnt = 0;
  int          nwords = 0;
  logic        cap_active = 1'b0;
  int          cap_bits = 0;
  logic [23:0] cap_word = '0;
  logic [23:0] words [0:63];
  logic        vlog [0:63];
  int          fs_rise [0:63];
  int          fs_cyc [0:63];
  int          mon_err = 0;

  always @(negedge clk_in) begin
    cyc <= cyc + 1;
    if (bit_clk && !bc_prev) begin
      rise_cnt = rise_cnt + 1;
      if (frame_sync) begin
        if (fs_prev) begin
          mon_err = mon_err + 1;
          $display("FAIL R6: frame marker high for 2 bit periods, got 2 expected 1");
        end
        if (fs_cnt < 64) begin
          vlog[fs_cnt]    = smp_valid;
          fs_rise[fs_cnt] = rise_cnt;
          fs_cyc[fs_cnt]  = cyc;
        end
        fs_cnt     = fs_cnt + 1;
        cap_word   = {23'd0, ser_data};
        cap_bits   = 1;
        cap_active = 1'b1;
      end else if (cap_active) begin
        cap_word = {cap_word[22:0], ser_data};
        cap_bits = cap_bits + 1;
      end
      fs_prev = frame_sync;
      if (cap_active && cap_bits == (frame_long ? 24 : 16)) begin
        if (nwords < 64) words[nwords] = cap_word;
        nwords     = nwords + 1;
        cap_active = 1'b0;
      end
    end
    bc_prev = bit_clk;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input string what, input int act, input int exp);
    chk(act == exp, req, what, act, exp);
  endtask

  task automatic send(input logic [23:0] d);
    @(negedge clk_in);
    smp_stb  = 1'b1;
    smp_data = d;
    @(negedge clk_in);
    smp_stb  = 1'b0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk_in);
  endtask

  task automatic half_periods(output int lo, output int hi);
    while (bit_clk) @(negedge clk_in);
    lo = 0;
    while (!bit_clk) begin @(negedge clk_in); lo++; end
    hi = 0;
    while (bit_clk) begin @(negedge clk_in); hi++; end
  endtask

  task automatic edges_to_first_fall(output int n);
    n = 0;
    do begin
      @(negedge clk_in);
      n++;
    end while (bit_clk && n < 100);
  endtask

  task automatic t_reset_state;
    chk_eq("R1", "bit_clk in reset", int'(bit_clk), 1);
    chk_eq("R1", "frame_sync in reset", int'(frame_sync), 0);
    chk_eq("R1", "ser_data in reset", int'(ser_data), 0);
    chk_eq("R1", "smp_valid in reset", int'(smp_valid), 0);
  endtask

  task automatic t_frame16;
    int base, lo, hi;
    div_half = 8'd2; frame_long = 1'b0;
    wait_n(10);
    base = nwords;
    send(24'hA5C37E);
    wait_n(100);
    chk_eq("R7", "16-bit frame count", nwords - base, 1);
    chk_eq("R7", "16-bit word", int'(words[base]), 'hA5C3);
    send(24'h3C5A11);
    half_periods(lo, hi);
    chk_eq("R5", "low time div 2", lo, 2);
    chk_eq("R5", "high time div 2", hi, 2);
    wait_n(100);
    chk_eq("R6", "MSB-first word", int'(words[base+1]), 'h3C5A);
  endtask

  task automatic t_frame24_b2b;
    int base, fb, lo, hi;
    div_half = 8'd3; frame_long = 1'b1;
    wait_n(20);
    base = nwords; fb = fs_cnt;
    send(24'h9B1E47);
    wait_n(10);
    send(24'h62D0F5);
    wait_n(330);
    chk_eq("R7", "24-bit first word", int'(words[base]), 'h9B1E47);
    chk_eq("R8", "held second word", int'(words[base+1]), 'h62D0F5);
    chk_eq("R8", "bit periods between markers", fs_rise[fb+1] - fs_rise[fb], 24);
    half_periods(lo, hi);
    chk_eq("R5", "low time div 3", lo, 3);
    chk_eq("R5", "high time div 3", hi, 3);
  endtask

  task automatic t_sync_hold_release;
    int n, fsc, lows;
    div_half = 8'd2; frame_long = 1'b0;
    wait_n(10);
    send(24'h5A5A5A);
    wait_n(20);
    @(negedge clk_in);
    sync_n = 1'b0;
    #1;
    chk_eq("R2", "bit_clk at once on sync", int'(bit_clk), 1);
    chk_eq("R2", "frame_sync at once on sync", int'(frame_sync), 0);
    send(24'h777777);  // discarded, R11
    lows = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk_in);
      if (!bit_clk || frame_sync) lows++;
    end
    chk_eq("R2", "cycles not idle while held", lows, 0);
    chk_eq("R2", "smp_valid while held", int'(smp_valid), 0);
    @(negedge clk_in);
    sync_n = 1'b1;
    edges_to_first_fall(n);
    chk_eq("R4", "edges to first fall div 2", n, 4);
    fsc = fs_cnt;
    wait_n(200);
    chk_eq("R11", "frames without new strobe", fs_cnt - fsc, 0);
  endtask

  task automatic burst(output int lat, output int fb);
    int rel;
    @(negedge clk_in);
    sync_n = 1'b0;
    wait_n(3);
    sync_n = 1'b1;
    rel = cyc;
    fb  = fs_cnt;
    wait_n(5);
    for (int i = 0; i < 14; i++) begin
      send(24'h100000 + 24'(i * 'h1357));
      wait_n(78);
    end
    wait_n(100);
    chk_eq("R9", "frames in burst", fs_cnt - fb, 14);
    lat = fs_cyc[fb] - rel;
  endtask

  task automatic t_valid_latency;
    int lat1, lat2, fb1, fb2, bad;
    div_half = 8'd2; frame_long = 1'b0;
    burst(lat1, fb1);
    bad = 0;
    for (int k = 0; k < 14; k++)
      if (vlog[fb1+k] != (k >= 11)) bad++;
    chk_eq("R9", "valid wrong on frames 1..14", bad, 0);
    chk_eq("R9", "valid on frame 11", int'(vlog[fb1+10]), 0);
    chk_eq("R9", "valid on frame 12", int'(vlog[fb1+11]), 1);
    burst(lat2, fb2);
    chk_eq("R10", "release-to-marker latency repeat", lat2, lat1);
    chk(lat1 > 4 && lat1 < 40, "R10", "latency range", lat1, 20);
    chk_eq("R9", "valid after burst", int'(smp_valid), 1);
  endtask

  task automatic t_short_sync;
    int n;
    @(negedge clk_in);
    #1 sync_n = 1'b0;
    #3 sync_n = 1'b1;
    chk_eq("R3", "smp_valid after short pulse", int'(smp_valid), 0);
    edges_to_first_fall(n);
    chk_eq("R3", "edges to first fall after short pulse", n, 4);
    chk_eq("R3", "smp_valid after restart", int'(smp_valid), 0);
  endtask

  initial begin
    rst_n = 1'b0; sync_n = 1'b1; div_half = 8'd2; frame_long = 1'b0;
    smp_stb = 1'b0; smp_data = '0;
    wait_n(3);
    t_reset_state();
    rst_n = 1'b1;
    wait_n(5);
    t_frame16();
    t_frame24_b2b();
    t_sync_hold_release();
    t_valid_latency();
    t_short_sync();
    wait_n(5);
    vectors += 1;
    errors  += mon_err;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule